// File: doc/BRIEF.md
# Half-Word FIFO DMA Request Generator

This block sits between a serial memory-card protocol engine and a system DMA controller. It holds a four-entry, 16-bit FIFO and drives one DMA request line from how full that FIFO is. The same FIFO carries data in both directions. In a receive transfer the engine fills the FIFO and the DMA controller drains it. In a transmit transfer the DMA controller fills it and the engine drains it. The `xfer_rx` input gives the direction of the current packet. Because the FIFO holds eight bytes, the DMA controller must use bursts of either one half-word (2 bytes) or four half-words (8 bytes). A 16-bit control word chooses which of these two burst sizes the request is matched to, and it also gates the request on or off.

Both data ports use valid/ready. `s_ready` is high while a slot is free, and `m_valid` is high while a word is held. The system contract is stricter than plain back-pressure: a source must not present `s_valid` while `s_ready` is low, and a sink must not raise `m_ready` while `m_valid` is low. A transfer attempted against the handshake is dropped, and it sets a sticky error flag.

A packet read from the card rarely ends on a burst boundary. The engine pulses `rx_last` together with the last data of a read packet. From then on the request stays raised until the FIFO is drained, so a short final burst is still fetched.

Top module: `hwq_dreq`

## Requirements
- R1: The FIFO keeps data in order and holds DEPTH=4 words. `s_ready` is high exactly when fewer than 4 words are held, and `m_valid` is high exactly when at least one word is held. `m_data` shows the oldest word.
- R2: While the enable bit (control bit 0) is 0, `dma_req` is low whatever the FIFO state.
- R3: In receive mode (`xfer_rx`=1) with the enable bit set, `dma_req` is high when the quad bit (control bit 1) is 1 and the FIFO holds 4 words. It is also high when the quad bit is 0 and the FIFO holds at least 1 word.
- R4: In transmit mode (`xfer_rx`=0) with the enable bit set, `dma_req` is high when the quad bit is 1 and the FIFO is empty. It is also high when the quad bit is 0 and the FIFO holds fewer than 4 words.
- R5: An `rx_last` pulse in receive mode that leaves data in the FIFO sets a pending last-burst request. While the enable bit is set, that request forces `dma_req` high. It clears when the FIFO becomes empty, and a later packet does not re-trigger it. An `rx_last` pulse in transmit mode has no effect.
- R6: The control word has the enable bit at bit 0 and the quad bit at bit 1, and both are writable. Bit 8 reads as 1 when the block is enabled in receive mode with a full FIFO. Bit 9 reads as 1 when the block is enabled in transmit mode with an empty FIFO. All other bits read 0, and writes to them are ignored.
- R7: Power-up reset (`rst_n` low) and the synchronous `soft_rst` each return the control word to 0x0000. They also flush the FIFO, clear the error flag and clear any pending last-burst request. `soft_rst` takes priority over a write in the same cycle.
- R8: A push while `s_ready` is low, or a pop while `m_valid` is low, leaves the FIFO contents unchanged. It sets `err_flag`, which stays set until a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous module reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word and status read value |
| xfer_rx | input | 1 | 1 = receive packet, 0 = transmit packet |
| rx_last | input | 1 | Pulse: last data of a read packet has arrived |
| s_valid | input | 1 | Push side valid |
| s_ready | output | 1 | Push side ready (slot free) |
| s_data | input | 16 | Push side half-word |
| m_valid | output | 1 | Pop side valid (word held) |
| m_ready | input | 1 | Pop side ready |
| m_data | output | 16 | Oldest half-word |
| dma_req | output | 1 | DMA request |
| err_flag | output | 1 | Sticky handshake-violation flag |

## Verification
The bench sweeps every combination of direction, burst size and enable against every fill level from 0 to 4. It checks the request and the status bits against arithmetic expectations. This catches a design that swaps the receive and transmit conditions, or that is off by one at the full or empty edge.

It also drives a short final read of two words. The request must appear with the last word, survive the first pop, drop on the last pop, and not return when the next packet starts. A design that forgets to clear this latch would keep requesting on stale data.

It pushes into a full FIFO and pops an empty one, and then checks the data order. A design that accepted the dropped word would return it out of order. A design that allowed a pop from an empty FIFO would underflow its count.

// File: rtl/hwq_dreq_pkg.sv
package hwq_dreq_pkg;

  localparam int REG_W        = 16;
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_QUAD_BIT = 1;
  localparam int ST_RFF_BIT   = 8;
  localparam int ST_TFE_BIT   = 9;

  typedef struct packed {
    logic quad;
    logic en;
  } cfg_t;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } dir_e;

endpackage

// File: rtl/hwq_fifo.sv
module hwq_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_valid,
  output logic          push_ready,
  input  logic [DW-1:0] push_data,
  output logic          pop_valid,
  input  logic          pop_ready,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] occ_next,
  output logic          bad_push,
  output logic          bad_pop
);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ_q;
  logic          do_push, do_pop;
  logic [DW-1:0] slots [DEPTH];

  assign push_ready = (occ_q != CW'(DEPTH));
  assign pop_valid  = (occ_q != '0);
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop_ready && pop_valid;
  assign bad_push   = push_valid && !push_ready;
  assign bad_pop    = pop_ready && !pop_valid;

  always_comb begin
    occ_next = occ_q;
    if (do_push && !do_pop) occ_next = occ_q + 1'b1;
    else if (do_pop && !do_push) occ_next = occ_q - 1'b1;
    if (flush) occ_next = '0;
  end

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      occ_q <= occ_next;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else if (do_push && !flush && wr_ptr == AW'(i)) slot_q <= push_data;
    end
    assign slots[i] = slot_q;
  end

  assign pop_data = slots[rd_ptr];
  assign occ      = occ_q;

endmodule

// File: rtl/hwq_cfg_reg.sv
module hwq_cfg_reg
  import hwq_dreq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             st_rff,
  input  logic             st_tfe,
  output cfg_t             cfg,
  output logic [REG_W-1:0] rdata
);

  cfg_t cfg_q;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[REG_W-1:CFG_QUAD_BIT+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (soft_rst) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q.en   <= wdata[CFG_EN_BIT];
      cfg_q.quad <= wdata[CFG_QUAD_BIT];
    end
  end

  always_comb begin
    rdata               = '0;
    rdata[CFG_EN_BIT]   = cfg_q.en;
    rdata[CFG_QUAD_BIT] = cfg_q.quad;
    rdata[ST_RFF_BIT]   = st_rff;
    rdata[ST_TFE_BIT]   = st_tfe;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/hwq_req_logic.sv
module hwq_req_logic
  import hwq_dreq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  cfg_t          cfg,
  input  dir_e          dir,
  input  logic [CW-1:0] occ,
  input  logic [CW-1:0] occ_next,
  input  logic          rx_last,
  input  logic          bad_push,
  input  logic          bad_pop,
  output logic          dma_req,
  output logic          st_rff,
  output logic          st_tfe,
  output logic          err
);

  logic full, empty, thr_hit, last_pend, err_q;

  assign full  = (occ == CW'(DEPTH));
  assign empty = (occ == '0);

  always_comb begin
    unique case ({dir, cfg.quad})
      {DIR_RX, 1'b1}: thr_hit = full;
      {DIR_RX, 1'b0}: thr_hit = !empty;
      {DIR_TX, 1'b1}: thr_hit = empty;
      default:        thr_hit = !full;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pend <= 1'b0;
      err_q     <= 1'b0;
    end else if (flush) begin
      last_pend <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (occ_next == '0) last_pend <= 1'b0;
      else if (rx_last && dir == DIR_RX) last_pend <= 1'b1;
      if (bad_push || bad_pop) err_q <= 1'b1;
    end
  end

  assign dma_req = cfg.en && (thr_hit || (last_pend && dir == DIR_RX));
  assign st_rff  = cfg.en && dir == DIR_RX && full;
  assign st_tfe  = cfg.en && dir == DIR_TX && empty;
  assign err     = err_q;

endmodule

// File: rtl/hwq_dreq.sv
module hwq_dreq
  import hwq_dreq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             xfer_rx,
  input  logic             rx_last,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [DW-1:0]    s_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [DW-1:0]    m_data,
  output logic             dma_req,
  output logic             err_flag
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] occ_w, occ_next_w;
  logic          bad_push_w, bad_pop_w;
  logic          st_rff_w, st_tfe_w;
  cfg_t          cfg_w;
  dir_e          dir_w;
  logic          cfg_en_w, cfg_quad_w;

  assign dir_w      = xfer_rx ? DIR_RX : DIR_TX;
  assign cfg_en_w   = cfg_w.en;
  assign cfg_quad_w = cfg_w.quad;

  hwq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (soft_rst),
    .push_valid (s_valid),
    .push_ready (s_ready),
    .push_data  (s_data),
    .pop_valid  (m_valid),
    .pop_ready  (m_ready),
    .pop_data   (m_data),
    .occ        (occ_w),
    .occ_next   (occ_next_w),
    .bad_push   (bad_push_w),
    .bad_pop    (bad_pop_w)
  );

  hwq_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .wr_en    (cfg_we),
    .wdata    (cfg_wdata),
    .st_rff   (st_rff_w),
    .st_tfe   (st_tfe_w),
    .cfg      (cfg_w),
    .rdata    (cfg_rdata)
  );

  hwq_req_logic #(.DEPTH(DEPTH)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (soft_rst),
    .cfg      (cfg_w),
    .dir      (dir_w),
    .occ      (occ_w),
    .occ_next (occ_next_w),
    .rx_last  (rx_last),
    .bad_push (bad_push_w),
    .bad_pop  (bad_pop_w),
    .dma_req  (dma_req),
    .st_rff   (st_rff_w),
    .st_tfe   (st_tfe_w),
    .err      (err_flag)
  );

endmodule

// File: rtl/hwq_dreq_checker.sv
module hwq_dreq_checker #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic [15:0]   cfg_rdata,
  input logic          xfer_rx,
  input logic          s_valid,
  input logic          s_ready,
  input logic          m_valid,
  input logic          m_ready,
  input logic          dma_req,
  input logic          err_flag,
  input logic [CW-1:0] occ,
  input logic          cfg_en,
  input logic          cfg_quad
);

  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> !dma_req);

  a_r3_rx_quad_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_quad && xfer_rx && occ == CW'(DEPTH)) |-> dma_req);

  a_r4_tx_quad_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_quad && !xfer_rx && occ == '0) |-> dma_req);

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  a_r8_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready && !(m_valid && m_ready) && !soft_rst) |=> occ == $past(occ));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !soft_rst) |=> err_flag);

  a_r7_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cfg_rdata == 16'h0000 && !err_flag && occ == '0));

endmodule

bind hwq_dreq hwq_dreq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .soft_rst  (soft_rst),
  .cfg_rdata (cfg_rdata),
  .xfer_rx   (xfer_rx),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .dma_req   (dma_req),
  .err_flag  (err_flag),
  .occ       (occ_w),
  .cfg_en    (cfg_en_w),
  .cfg_quad  (cfg_quad_w)
);

// File: tb/hwq_dreq_tb.sv
module hwq_dreq_tb;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        xfer_rx = 1'b0;
  logic        rx_last = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [15:0] m_data;
  logic        dma_req;
  logic        err_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hwq_dreq u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .xfer_rx(xfer_rx), .rx_last(rx_last),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .dma_req(dma_req), .err_flag(err_flag)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input logic [15:0] d, input logic last);
    s_valid = 1'b1; s_data = d; rx_last = last;
    tick();
    s_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic pop();
    m_ready = 1'b1;
    tick();
    m_ready = 1'b0;
  endtask

  task automatic sreset();
    soft_rst = 1'b1;
    tick();
    soft_rst = 1'b0;
  endtask

  task automatic wcfg(input logic [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R7: power-up state
    chk("R7 reset cfg_rdata", cfg_rdata, 16'h0000);
    chk("R7 reset dma_req", dma_req, 0);
    chk("R7 reset err_flag", err_flag, 0);
    chk("R1 reset m_valid", m_valid, 0);
    chk("R1 reset s_ready", s_ready, 1);

    // R2 R3 R4 R6: sweep direction x quad x enable x fill level
    for (int dir = 0; dir < 2; dir++)
      for (int quad = 0; quad < 2; quad++)
        for (int en = 0; en < 2; en++)
          for (int n = 0; n <= DEPTH; n++) begin
            logic exp_req;
            logic [15:0] exp_rd;
            sreset();
            xfer_rx = dir[0];
            wcfg({14'h0, quad[0], en[0]});
            for (int k = 0; k < n; k++) push(16'(k), 1'b0);
            if (dir == 1) exp_req = (quad == 1) ? (n == DEPTH) : (n >= 1);
            else          exp_req = (quad == 1) ? (n == 0) : (n < DEPTH);
            exp_req = exp_req && (en == 1);
            chk(dir == 1 ? "R3 rx request" : (en == 1 ? "R4 tx request" : "R2 disabled"),
                dma_req, exp_req);
            exp_rd = {6'h0, (en == 1 && dir == 0 && n == 0), (en == 1 && dir == 1 && n == DEPTH),
                      6'h0, quad[0], en[0]};
            chk("R6 status bits", cfg_rdata, exp_rd);
            chk("R1 s_ready level", s_ready, n < DEPTH);
            chk("R1 m_valid level", m_valid, n > 0);
          end

    // R6: reserved bits ignored
    sreset();
    xfer_rx = 1'b1;
    wcfg(16'hFFFF);
    chk("R6 reserved write rx", cfg_rdata, 16'h0003);
    xfer_rx = 1'b0;
    tick();
    chk("R6 reserved write tx", cfg_rdata, 16'h0203);

    // R8: push into full, data order, pop from empty
    sreset();
    xfer_rx = 1'b1;
    wcfg(16'h0003);
    for (int k = 0; k < DEPTH; k++) push(16'h0100 + 16'(k), 1'b0);
    chk("R8 no error yet", err_flag, 0);
    push(16'hDEAD, 1'b0);
    chk("R8 overfull push sets err", err_flag, 1);
    chk("R8 still full", cfg_rdata[8], 1);
    for (int k = 0; k < DEPTH; k++) begin
      chk("R1 R8 order and drop", m_data, 16'h0100 + 16'(k));
      pop();
    end
    chk("R8 empty after drain", m_valid, 0);
    pop();
    chk("R8 empty pop keeps empty", m_valid, 0);
    chk("R8 err sticky", err_flag, 1);
    sreset();
    chk("R7 soft clears err", err_flag, 0);
    chk("R7 soft clears cfg", cfg_rdata, 16'h0000);
    pop();
    chk("R8 empty pop sets err", err_flag, 1);
    push(16'h0055, 1'b0);
    chk("R8 after underflow data", m_data, 16'h0055);

    // R7: soft reset beats a write in the same cycle
    sreset();
    cfg_we = 1'b1; cfg_wdata = 16'h0003; soft_rst = 1'b1;
    tick();
    cfg_we = 1'b0; soft_rst = 1'b0;
    chk("R7 soft over write", cfg_rdata, 16'h0000);

    // R5: short final read burst
    sreset();
    xfer_rx = 1'b1;
    wcfg(16'h0003);
    push(16'h00A0, 1'b0);
    chk("R5 below threshold", dma_req, 0);
    push(16'h00A1, 1'b1);
    chk("R5 last burst request", dma_req, 1);
    pop();
    chk("R5 held after first pop", dma_req, 1);
    pop();
    chk("R5 cleared when empty", dma_req, 0);
    push(16'h00B0, 1'b0);
    chk("R5 no retrigger", dma_req, 0);

    // R5: ignored in transmit mode
    sreset();
    xfer_rx = 1'b0;
    wcfg(16'h0003);
    push(16'h00C0, 1'b0);
    push(16'h00C1, 1'b1);
    chk("R5 tx ignores rx_last", dma_req, 0);

    // R2 R5: pending kept while disabled, gated at output
    sreset();
    xfer_rx = 1'b1;
    wcfg(16'h0002);
    push(16'h00D0, 1'b1);
    chk("R2 pending gated off", dma_req, 0);
    wcfg(16'h0003);
    chk("R5 pending after enable", dma_req, 1);

    finish_run();
  end

endmodule